// File: doc/BRIEF.md
# Receive Buffer Chaining Engine

This block moves a received network frame out of a network controller and into host memory. Frame data is handed over in chunks of sixteen bytes, and the last chunk of a frame may be shorter. The engine asks a descriptor source for a host buffer, given as a base address and a length in bytes. It then writes the frame into that buffer one byte per cycle at ascending addresses.

When a buffer runs out while frame data remains, the engine closes that buffer and fetches the next descriptor. It then continues at the start of the new buffer. A chunk that only partly fits is split: its leading bytes complete the old buffer and its trailing bytes open the new one. No byte is skipped and none is repeated.

Every closed buffer is reported on a write-back port. The report carries the number of bytes placed in that buffer, a start flag on the first buffer of the frame and an end flag on the last. The end report also carries the frame's total byte count. If the descriptor source has no buffer left, the rest of the frame is consumed and discarded, and the end report carries an error flag.

Top module: `rx_chain_engine`

## Requirements
- R1: A chunk is taken when `chk_valid` and `chk_ready` are both high at a clock edge. Byte k of a chunk sits in `chk_data[8k+7:8k]` and byte 0 is written first. A chunk with `chk_last` low carries 16 bytes. A chunk with `chk_last` high carries `chk_bytes` bytes, from 1 to 16.
- R2: Each cycle with `wr_en` high writes one byte. The address is `base + offset`, and the offset counts the bytes already placed in the current buffer. Frame bytes appear in order, with none skipped or duplicated.
- R3: A chunk larger than the space left in the current buffer fills that buffer to its last byte. Its remaining bytes go to offset 0 of the next buffer.
- R4: A new descriptor is requested only at frame start and when the current buffer is full with frame data still to come. A frame that ends exactly on a buffer's last byte causes no further request.
- R5: Each closed buffer produces a one-cycle `wb_valid` report. The report holds the byte count in `wb_fill`. `wb_sof` is set only on the first buffer of the frame, and `wb_eof` only on the final report.
- R6: The final report of a frame gives in `wb_total` the number of frame bytes written to memory.
- R7: A descriptor grant with `desc_empty` high while frame data remains makes the engine accept and discard the rest of the frame. It then gives a final report with `wb_eof` and `wb_err` set and `wb_fill` equal to 0.
- R8: `desc_req` stays high until a cycle with `desc_gnt` high. `desc_empty`, `desc_base` and `desc_size` are sampled in that cycle. `desc_size` is at least 1.
- R9: A low `rst_n` at a clock edge returns the engine to idle. A partly received frame is dropped, producing no report and no further writes.
- R10: `chk_ready` is low while a descriptor is being fetched and while bytes are being written. A frame's first chunk is not taken before its first descriptor grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chk_valid | input | 1 | Chunk offered |
| chk_ready | output | 1 | Engine takes the offered chunk |
| chk_data | input | 128 | Chunk bytes, byte 0 in the low lane |
| chk_last | input | 1 | Chunk ends the frame |
| chk_bytes | input | 5 | Valid bytes in a last chunk (1 to 16) |
| desc_req | output | 1 | Descriptor wanted |
| desc_gnt | input | 1 | Descriptor answer present |
| desc_empty | input | 1 | No buffer available in this answer |
| desc_base | input | 16 | Buffer base byte address |
| desc_size | input | 11 | Buffer length in bytes |
| wr_en | output | 1 | Memory byte write |
| wr_addr | output | 16 | Memory byte address |
| wr_data | output | 8 | Memory byte value |
| wb_valid | output | 1 | Buffer report |
| wb_sof | output | 1 | Report is for the frame's first buffer |
| wb_eof | output | 1 | Final report of the frame |
| wb_err | output | 1 | Frame truncated for lack of buffers |
| wb_fill | output | 11 | Bytes placed in the reported buffer |
| wb_total | output | 11 | Frame bytes stored (meaningful with wb_eof) |

## Verification
Two events can fall on the same byte: a chunk can run out in the cycle where the buffer also fills, and the final byte of a frame can be the final byte of a buffer. The bench provokes both. It uses buffers of 16 and 32 bytes so that buffer ends line up with chunk ends. It uses odd sizes such as 10 and 7 so that chunks split in the middle. A 32-byte frame goes into a single 32-byte buffer. The scoreboard compares every byte address and value and every report against a model that walks the frame byte by byte. The descriptor grants are counted to show that an exact fit asks for no extra buffer.

// File: rtl/rxc_pkg.sv
// Shared types for the receive buffer chaining engine.
package rxc_pkg;
    // Controller states: wait for a frame, fetch a buffer, take a chunk,
    // write bytes, discard the rest of a frame.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_LOAD  = 3'd2,
        ST_MOVE  = 3'd3,
        ST_DROP  = 3'd4
    } rxc_state_e;
endpackage

// File: rtl/rxc_chunk_reg.sv
// Holds one received chunk and serves its bytes in lane order.
// Assumes: load and adv are never high together; a loaded chunk holds
// at least one byte.
module rxc_chunk_reg #(
    parameter int CHUNK_BYTES = 16,
    localparam int DATA_W = CHUNK_BYTES * 8,
    localparam int CNT_W  = $clog2(CHUNK_BYTES + 1),
    localparam int IDX_W  = $clog2(CHUNK_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic [CNT_W-1:0]  in_cnt,
    input  logic              adv,
    output logic [7:0]        cur_byte,
    output logic              at_end,
    output logic              is_last
);
    logic [DATA_W-1:0] data_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic              last_q;
    logic [7:0]        lane [CHUNK_BYTES];

    // Split the held chunk into byte lanes.
    for (genvar g = 0; g < CHUNK_BYTES; g++) begin : g_lane
        assign lane[g] = data_q[g*8 +: 8];
    end

    // Capture a chunk, or step to the next byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            cnt_q  <= '0;
            idx_q  <= '0;
            last_q <= 1'b0;
        end else if (load) begin
            data_q <= in_data;
            cnt_q  <= in_last ? in_cnt : CNT_W'(CHUNK_BYTES);
            idx_q  <= '0;
            last_q <= in_last;
        end else if (adv) begin
            idx_q  <= idx_q + IDX_W'(1);
        end
    end

    // Current byte and end-of-chunk flag.
    always_comb begin
        cur_byte = lane[idx_q];
        at_end   = (CNT_W'(idx_q) + CNT_W'(1)) == cnt_q;
        is_last  = last_q;
    end
endmodule

// File: rtl/rxc_buf_track.sv
// Tracks the current host buffer: base, length and bytes placed so far.
// Assumes: a buffer length is at least one byte.
module rxc_buf_track #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [LEN_W-1:0]  size_in,
    input  logic              adv,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [LEN_W-1:0]  fill_next,
    output logic              at_full
);
    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  size_q;
    logic [LEN_W-1:0]  fill_q;

    // Open a new buffer, or count a written byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            size_q <= '0;
            fill_q <= '0;
        end else if (open) begin
            base_q <= base_in;
            size_q <= size_in;
            fill_q <= '0;
        end else if (adv) begin
            fill_q <= fill_q + LEN_W'(1);
        end
    end

    // Address of the next byte; full when this byte is the buffer's last.
    always_comb begin
        cur_addr  = base_q + ADDR_W'(fill_q);
        fill_next = fill_q + LEN_W'(1);
        at_full   = (fill_next == size_q);
    end
endmodule

// File: rtl/rxc_ctrl.sv
// Sequencing for the chaining engine: descriptor fetch, chunk intake,
// byte moves, buffer close reports and frame discard.
// Assumes: ch_* and buf_* inputs describe the chunk and buffer in use.
module rxc_ctrl
    import rxc_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_valid,
    input  logic             chk_last_in,
    input  logic             desc_gnt,
    input  logic             desc_empty,
    input  logic             ch_end,
    input  logic             ch_last,
    input  logic             buf_full,
    input  logic [LEN_W-1:0] buf_fill_next,
    output logic             chk_ready,
    output logic             desc_req,
    output logic             wr_en,
    output logic             ch_load,
    output logic             buf_open,
    output logic             wb_valid,
    output logic             wb_sof,
    output logic             wb_eof,
    output logic             wb_err,
    output logic [LEN_W-1:0] wb_fill,
    output logic [LEN_W-1:0] wb_total
);
    rxc_state_e       st_q;
    logic             first_q;
    logic             pend_q;
    logic [LEN_W-1:0] total_q;

    // Handshake and datapath strobes decoded from the state.
    always_comb begin
        chk_ready = (st_q == ST_LOAD) || (st_q == ST_DROP);
        desc_req  = (st_q == ST_FETCH);
        wr_en     = (st_q == ST_MOVE);
        ch_load   = (st_q == ST_LOAD) && chk_valid;
        buf_open  = (st_q == ST_FETCH) && desc_gnt && !desc_empty;
    end

    // State transitions, frame counters and buffer report registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            first_q  <= 1'b0;
            pend_q   <= 1'b0;
            total_q  <= '0;
            wb_valid <= 1'b0;
            wb_sof   <= 1'b0;
            wb_eof   <= 1'b0;
            wb_err   <= 1'b0;
            wb_fill  <= '0;
            wb_total <= '0;
        end else begin
            wb_valid <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (chk_valid) begin
                        st_q    <= ST_FETCH;
                        first_q <= 1'b1;
                        pend_q  <= 1'b0;
                        total_q <= '0;
                    end
                end
                ST_FETCH: begin
                    if (desc_gnt) begin
                        if (desc_empty) begin
                            pend_q <= 1'b0;
                            if (pend_q && ch_last) begin
                                wb_valid <= 1'b1;
                                wb_sof   <= first_q;
                                wb_eof   <= 1'b1;
                                wb_err   <= 1'b1;
                                wb_fill  <= '0;
                                wb_total <= total_q;
                                st_q     <= ST_IDLE;
                            end else begin
                                st_q     <= ST_DROP;
                            end
                        end else begin
                            st_q <= pend_q ? ST_MOVE : ST_LOAD;
                        end
                    end
                end
                ST_LOAD: begin
                    if (chk_valid) begin
                        st_q   <= ST_MOVE;
                        pend_q <= 1'b1;
                    end
                end
                ST_MOVE: begin
                    total_q <= total_q + LEN_W'(1);
                    if (ch_end && ch_last) begin
                        wb_valid <= 1'b1;
                        wb_sof   <= first_q;
                        wb_eof   <= 1'b1;
                        wb_err   <= 1'b0;
                        wb_fill  <= buf_fill_next;
                        wb_total <= total_q + LEN_W'(1);
                        st_q     <= ST_IDLE;
                    end else if (buf_full) begin
                        wb_valid <= 1'b1;
                        wb_sof   <= first_q;
                        wb_eof   <= 1'b0;
                        wb_err   <= 1'b0;
                        wb_fill  <= buf_fill_next;
                        wb_total <= total_q + LEN_W'(1);
                        first_q  <= 1'b0;
                        pend_q   <= !ch_end;
                        st_q     <= ST_FETCH;
                    end else if (ch_end) begin
                        pend_q   <= 1'b0;
                        st_q     <= ST_LOAD;
                    end
                end
                ST_DROP: begin
                    if (chk_valid && chk_last_in) begin
                        wb_valid <= 1'b1;
                        wb_sof   <= first_q;
                        wb_eof   <= 1'b1;
                        wb_err   <= 1'b1;
                        wb_fill  <= '0;
                        wb_total <= total_q;
                        st_q     <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rx_chain_engine.sv
// Receive buffer chaining engine: writes chunked frame data byte by byte
// into a chain of host buffers and reports each buffer as it closes.
// Assumes: descriptor lengths are nonzero; a last chunk holds 1..CHUNK_BYTES.
module rx_chain_engine #(
    parameter int CHUNK_BYTES = 16,
    parameter int ADDR_W      = 16,
    parameter int LEN_W       = 11,
    localparam int DATA_W = CHUNK_BYTES * 8,
    localparam int CNT_W  = $clog2(CHUNK_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_valid,
    output logic              chk_ready,
    input  logic [DATA_W-1:0] chk_data,
    input  logic              chk_last,
    input  logic [CNT_W-1:0]  chk_bytes,
    output logic              desc_req,
    input  logic              desc_gnt,
    input  logic              desc_empty,
    input  logic [ADDR_W-1:0] desc_base,
    input  logic [LEN_W-1:0]  desc_size,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wb_valid,
    output logic              wb_sof,
    output logic              wb_eof,
    output logic              wb_err,
    output logic [LEN_W-1:0]  wb_fill,
    output logic [LEN_W-1:0]  wb_total
);
    logic             ch_load;
    logic             ch_end;
    logic             ch_last;
    logic             buf_open;
    logic             buf_full;
    logic [LEN_W-1:0] buf_fill_next;

    rxc_chunk_reg #(.CHUNK_BYTES(CHUNK_BYTES)) u_chunk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ch_load),
        .in_data  (chk_data),
        .in_last  (chk_last),
        .in_cnt   (chk_bytes),
        .adv      (wr_en),
        .cur_byte (wr_data),
        .at_end   (ch_end),
        .is_last  (ch_last)
    );

    rxc_buf_track #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .open      (buf_open),
        .base_in   (desc_base),
        .size_in   (desc_size),
        .adv       (wr_en),
        .cur_addr  (wr_addr),
        .fill_next (buf_fill_next),
        .at_full   (buf_full)
    );

    rxc_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .chk_valid     (chk_valid),
        .chk_last_in   (chk_last),
        .desc_gnt      (desc_gnt),
        .desc_empty    (desc_empty),
        .ch_end        (ch_end),
        .ch_last       (ch_last),
        .buf_full      (buf_full),
        .buf_fill_next (buf_fill_next),
        .chk_ready     (chk_ready),
        .desc_req      (desc_req),
        .wr_en         (wr_en),
        .ch_load       (ch_load),
        .buf_open      (buf_open),
        .wb_valid      (wb_valid),
        .wb_sof        (wb_sof),
        .wb_eof        (wb_eof),
        .wb_err        (wb_err),
        .wb_fill       (wb_fill),
        .wb_total      (wb_total)
    );
endmodule

// File: rtl/rx_chain_engine_chk.sv
// Protocol and ordering checks for the chaining engine, bound to its top.
module rx_chain_engine_chk #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chk_ready,
    input logic              desc_req,
    input logic              desc_gnt,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wb_valid,
    input logic              wb_eof,
    input logic              wb_err,
    input logic [LEN_W-1:0]  wb_fill,
    input logic [LEN_W-1:0]  wb_total
);
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && $past(wr_en) |-> wr_addr == $past(wr_addr) + ADDR_W'(1)); // R2
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        desc_req && !desc_gnt |=> desc_req); // R8
    AST_NO_TAKE_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        chk_ready |-> !desc_req && !wr_en); // R10
    AST_ERR_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && wb_err |-> wb_eof && wb_fill == '0); // R7
    AST_FILL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_err |-> wb_fill != '0); // R5
    AST_REPORT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !wb_valid); // R5
    AST_TOTAL_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && wb_eof && !wb_err |-> wb_total >= wb_fill); // R6
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> !wr_en && !wb_valid && !chk_ready && !desc_req); // R9
endmodule

bind rx_chain_engine rx_chain_engine_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_ready (chk_ready),
    .desc_req  (desc_req),
    .desc_gnt  (desc_gnt),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wb_valid  (wb_valid),
    .wb_eof    (wb_eof),
    .wb_err    (wb_err),
    .wb_fill   (wb_fill),
    .wb_total  (wb_total)
);

// File: tb/rx_chain_engine_tb.sv
// Scoreboard bench: a frame task predicts writes and reports, a monitor
// pops and compares them as the engine produces them.
module rx_chain_engine_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         chk_valid = 1'b0;
    logic         chk_ready;
    logic [127:0] chk_data = '0;
    logic         chk_last = 1'b0;
    logic [4:0]   chk_bytes = 5'd16;
    logic         desc_req;
    logic         desc_gnt = 1'b0;
    logic         desc_empty = 1'b0;
    logic [15:0]  desc_base = '0;
    logic [10:0]  desc_size = '0;
    logic         wr_en;
    logic [15:0]  wr_addr;
    logic [7:0]   wr_data;
    logic         wb_valid, wb_sof, wb_eof, wb_err;
    logic [10:0]  wb_fill, wb_total;

    int checks = 0;
    int errors = 0;
    int grant_cnt = 0;
    bit mon_on = 1'b0;
    string cur_tag = "R2";

    logic [23:0] exp_wr[$];
    logic [24:0] exp_wb[$];
    logic [15:0] dq_base[$];
    logic [10:0] dq_size[$];

    always #2 clk = ~clk;

    rx_chain_engine u_dut (
        .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_ready(chk_ready),
        .chk_data(chk_data), .chk_last(chk_last), .chk_bytes(chk_bytes),
        .desc_req(desc_req), .desc_gnt(desc_gnt), .desc_empty(desc_empty),
        .desc_base(desc_base), .desc_size(desc_size), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .wb_valid(wb_valid),
        .wb_sof(wb_sof), .wb_eof(wb_eof), .wb_err(wb_err),
        .wb_fill(wb_fill), .wb_total(wb_total)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 7 + i) & 255);
    endfunction

    // Monitor: compare each write and each report with the scoreboard.
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            if (wr_en) begin
                if (exp_wr.size() == 0) begin
                    check(1'b0, cur_tag, "unexpected write", {16'h0, wr_addr}, 32'h0);
                end else begin
                    logic [23:0] e;
                    e = exp_wr.pop_front();
                    check({wr_addr, wr_data} == e, cur_tag, "write addr/data",
                          {8'h0, wr_addr, wr_data}, {8'h0, e});
                end
            end
            if (wb_valid) begin
                logic [24:0] a;
                a = {wb_sof, wb_eof, wb_err, wb_fill, wb_total};
                if (exp_wb.size() == 0) begin
                    check(1'b0, "R5", "unexpected report", {7'h0, a}, 32'h0);
                end else begin
                    logic [24:0] e;
                    e = exp_wb.pop_front();
                    check(a == e, e[22] ? "R7" : (e[23] ? "R6" : "R5"),
                          "report sof/eof/err/fill/total", {7'h0, a}, {7'h0, e});
                end
            end
        end
    end

    // Descriptor source: answer after a varying delay; empty when out.
    initial begin
        forever begin
            @(negedge clk);
            if (desc_req && rst_n) begin
                for (int d = 0; d < 1 + (grant_cnt % 3); d++) begin
                    @(negedge clk);
                    check(desc_req == 1'b1, "R8", "request held while waiting",
                          {31'h0, desc_req}, 32'h1);
                end
                desc_gnt = 1'b1;
                if (dq_size.size() == 0) begin
                    desc_empty = 1'b1;
                end else begin
                    desc_empty = 1'b0;
                    desc_base  = dq_base.pop_front();
                    desc_size  = dq_size.pop_front();
                end
                grant_cnt++;
                @(negedge clk);
                desc_gnt   = 1'b0;
                desc_empty = 1'b0;
            end
        end
    end

    // Push expected items for a frame, then drive its chunks.
    task automatic run_frame(input int len, input int seed, input string tag);
        int k, fill, stored, nd;
        bit first, dropped;
        logic [15:0] b[$];
        logic [10:0] s[$];
        b = dq_base; s = dq_size;
        nd = s.size();
        cur_tag = tag;
        k = 0; fill = 0; stored = 0; first = 1'b1; dropped = 1'b0;
        if (nd == 0) begin
            exp_wb.push_back({1'b1, 1'b1, 1'b1, 11'd0, 11'd0});
            dropped = 1'b1;
        end
        for (int i = 0; i < len && !dropped; i++) begin
            exp_wr.push_back({b[k] + 16'(fill), pat(seed, i)});
            fill++; stored++;
            if (i == len - 1) begin
                exp_wb.push_back({first, 1'b1, 1'b0, 11'(fill), 11'(stored)});
            end else if (fill == int'(s[k])) begin
                exp_wb.push_back({first, 1'b0, 1'b0, 11'(fill), 11'(stored)});
                first = 1'b0; k++; fill = 0;
                if (k >= nd) begin
                    exp_wb.push_back({1'b0, 1'b1, 1'b1, 11'd0, 11'(stored)});
                    dropped = 1'b1;
                end
            end
        end
        for (int c = 0; c * 16 < len; c++) begin
            int nb;
            nb = (len - c * 16 > 16) ? 16 : len - c * 16;
            @(posedge clk); #1;
            for (int j = 0; j < 16; j++)
                chk_data[j*8 +: 8] = (j < nb) ? pat(seed, c * 16 + j) : 8'h00;
            chk_last  = ((c + 1) * 16 >= len);
            chk_bytes = 5'(nb);
            chk_valid = 1'b1;
            if (c == 0) begin
                @(negedge clk);
                check(chk_ready == 1'b0, "R10", "no take before a grant",
                      {31'h0, chk_ready}, 32'h0);
            end
            do @(negedge clk); while (!chk_ready);
            @(posedge clk); #1;
            chk_valid = 1'b0;
        end
    endtask

    // Wait for the scoreboard to drain and the engine to go quiet.
    task automatic wait_drain();
        for (int t = 0; t < 4000 && (exp_wr.size() != 0 || exp_wb.size() != 0); t++)
            @(negedge clk);
        repeat (6) @(negedge clk);
        check(exp_wr.size() == 0, cur_tag, "writes left over", exp_wr.size(), 0);
        check(exp_wb.size() == 0, "R5", "reports left over", exp_wb.size(), 0);
    endtask

    task automatic add_desc(input logic [15:0] base, input logic [10:0] size);
        dq_base.push_back(base);
        dq_size.push_back(size);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R2", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int g0;
        repeat (3) @(negedge clk);
        check(!chk_ready && !desc_req && !wr_en && !wb_valid, "R9", "idle in reset",
              {28'h0, chk_ready, desc_req, wr_en, wb_valid}, 32'h0);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // Short last chunk into one large buffer.
        add_desc(16'h1000, 11'd100);
        run_frame(40, 1, "R1");
        wait_drain();

        // Odd-size buffers split chunks mid-way.
        g0 = grant_cnt;
        for (int i = 0; i < 7; i++) add_desc(16'h2000 + 16'(i * 32), 11'd10);
        run_frame(64, 2, "R3");
        wait_drain();
        check(grant_cnt - g0 == 7, "R4", "grants for split frame", grant_cnt - g0, 7);

        // Frame ends exactly at buffer end: no further request.
        g0 = grant_cnt;
        add_desc(16'h3000, 11'd32);
        run_frame(32, 3, "R4");
        wait_drain();
        check(grant_cnt - g0 == 1, "R4", "grants for exact fit", grant_cnt - g0, 1);

        // Buffer ends on a chunk end with data still to come.
        add_desc(16'h3100, 11'd16);
        add_desc(16'h3200, 11'd16);
        add_desc(16'h3300, 11'd16);
        run_frame(40, 4, "R3");
        wait_drain();

        // Out of buffers mid-frame: truncate and flag.
        add_desc(16'h4000, 11'd7);
        add_desc(16'h4100, 11'd5);
        run_frame(40, 5, "R7");
        wait_drain();

        // No buffer at all.
        run_frame(20, 6, "R7");
        wait_drain();

        // Single-byte frame.
        add_desc(16'h5000, 11'd8);
        run_frame(1, 7, "R1");
        wait_drain();

        // Full-size frame across six buffers.
        for (int i = 0; i < 6; i++) add_desc(16'h6000 + 16'(i * 512), 11'd256);
        run_frame(1500, 8, "R6");
        wait_drain();

        // Reset in the middle of a frame.
        mon_on = 1'b0;
        add_desc(16'h7000, 11'd64);
        @(posedge clk); #1;
        for (int j = 0; j < 16; j++) chk_data[j*8 +: 8] = 8'(j);
        chk_last = 1'b0; chk_bytes = 5'd16; chk_valid = 1'b1;
        do @(negedge clk); while (!chk_ready);
        @(posedge clk); #1;
        chk_valid = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!chk_ready && !desc_req && !wr_en && !wb_valid, "R9", "idle after reset",
              {28'h0, chk_ready, desc_req, wr_en, wb_valid}, 32'h0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int t = 0; t < 8; t++) begin
            @(negedge clk);
            check(!wb_valid && !wr_en, "R9", "no report after reset",
                  {30'h0, wb_valid, wr_en}, 32'h0);
        end
        dq_base.delete(); dq_size.delete();
        mon_on = 1'b1;

        // Engine works normally after reset.
        add_desc(16'h7800, 11'd20);
        add_desc(16'h7900, 11'd20);
        run_frame(33, 9, "R9");
        wait_drain();

        finish_run();
    end
endmodule